// File: doc/BRIEF.md
# Two-Entry Serial Receive Buffer

This block sits on the receive side of an asynchronous serial port, between the deserializer and a processor read port. Every completed character is handed over as a 9-bit value together with its stop-bit and parity results. The block keeps up to two such characters in a small first-in first-out store. It can park one more character in a hold stage, which stands for the receive shift register. Each entry keeps its own error flags, and those flags reach the outputs along with the entry's data.

The processor sees the oldest entry on the outputs: the low byte, the ninth bit, the frame-error flag and the parity-error flag. A receive-complete flag tells it when unread data exists. A one-cycle read strobe takes one entry out. Software samples the ninth bit before it issues that strobe.

An overrun flag reports a new start bit that arrives while both entries and the hold stage are all occupied. Dropping the receiver enable empties everything and clears every flag.

Top module: `rx_buf_top`

## Requirements
- R1: The store holds at most two characters and returns them in arrival order. A one-cycle `readPop` while `rxComplete` is high removes exactly the head entry.
- R2: `rxComplete` is high exactly when at least one unread entry is stored. After reset it is low, and `rxData`, `rxBit8`, `frameErr`, `parityErr` and `overrun` read 0.
- R3: `frameErr` shows the stop-bit-zero indication (`charFrameErr`) that belonged to the head entry when it arrived. The flag moves with its entry through the store.
- R4: `parityErr` shows, for the head entry, the value `charParityBad` AND `parityCheckEn`, both sampled in the cycle the character arrived. A bad parity received while checking is off reads as 0.
- R5: `overrun` is set in the cycle after `startDetect` is seen while both entries are full, a character is held, and no read occurs. In every other case `startDetect` leaves `overrun` unchanged.
- R6: Once set, `overrun` stays high until the next read pops an entry. That pop clears it.
- R7: While `rxEnable` is low, the cycle after it is sampled low shows an empty store, an empty hold stage, and `rxComplete`, `overrun`, `frameErr` and `parityErr` all at 0. `charValid`, `startDetect` and `readPop` have no effect while `rxEnable` is low.
- R8: `rxData` carries bits 7:0 and `rxBit8` carries bit 8 of the head character. Both stay unchanged until that entry is popped, even if new characters arrive in the meantime.
- R9: A character that arrives while both entries are full waits in the hold stage. It moves into the store in the same cycle as the next pop. A character that arrives while the store and the hold stage are both full is discarded.
- R10: A character arriving in the same cycle as a pop, with exactly one entry stored, leaves one entry stored. The new character becomes the head and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enable; low flushes the buffer |
| charValid | input | 1 | One-cycle strobe: a completed character is offered |
| charData | input | DATA_W | Completed character, bit 8 is the ninth bit |
| charFrameErr | input | 1 | First stop bit of the offered character was 0 |
| charParityBad | input | 1 | Parity of the offered character mismatched |
| parityCheckEn | input | 1 | Parity checking enabled at arrival time |
| startDetect | input | 1 | A new start bit has been detected on the line |
| readPop | input | 1 | Processor read of the low byte; pops the head |
| rxData | output | 8 | Low byte of the head entry |
| rxBit8 | output | 1 | Ninth bit of the head entry |
| rxComplete | output | 1 | Unread data present |
| frameErr | output | 1 | Frame error of the head entry |
| parityErr | output | 1 | Parity error of the head entry |
| overrun | output | 1 | Data overrun detected |

## Verification
Several properties are checked by assertions on every cycle:
- the occupancy never exceeds two entries;
- a low enable empties the store and clears the overrun flag;
- the overrun condition sets the flag;
- a pop with a held character keeps the store full;
- a simultaneous push and pop at one entry keeps one entry;
- the head's data is stable until it is popped.

Some behaviours are shown only by the bench scenarios:
- arrival order across the hold stage;
- error flags that travel with their own entry;
- the parity flag masked by the enable sampled at arrival;
- a discarded fourth character;
- inputs that are ignored while the receiver is disabled.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  typedef struct packed {
    logic flush;
    logic push;
    logic pushFromHold;
    logic loadHold;
    logic pop;
  } rxBufStrobes_t;
endpackage

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl
  import rx_buf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxEnable,
  input  logic          charValid,
  input  logic          startDetect,
  input  logic          readPop,
  output rxBufStrobes_t strb,
  output logic          headValid,
  output logic          overrunFlag
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             holdValid;
  logic             holdNext;
  logic             popOk;
  logic             room;
  logic             overrunSet;

  always_comb begin
    strb     = '0;
    holdNext = holdValid;
    popOk    = rxEnable && readPop && (count != '0);
    room     = (count < FULL) || popOk;
    if (!rxEnable) begin
      strb.flush = 1'b1;
      holdNext   = 1'b0;
    end else begin
      strb.pop = popOk;
      if (holdValid) begin
        if (room) begin
          strb.push         = 1'b1;
          strb.pushFromHold = 1'b1;
          strb.loadHold     = charValid;
          holdNext          = charValid;
        end
      end else if (charValid) begin
        if (room) begin
          strb.push = 1'b1;
        end else begin
          strb.loadHold = 1'b1;
          holdNext      = 1'b1;
        end
      end
    end
    overrunSet = rxEnable && startDetect && (count == FULL) && holdValid && !popOk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      holdValid   <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      holdValid <= holdNext;
      if (strb.flush) begin
        count       <= '0;
        overrunFlag <= 1'b0;
      end else begin
        case ({strb.push, strb.pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
        if (popOk)           overrunFlag <= 1'b0;
        else if (overrunSet) overrunFlag <= 1'b1;
      end
    end
  end

  assign headValid = (count != '0);

  // R1: occupancy bound
  p_count_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  // R7: disable flushes
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (!headValid && !overrunFlag));

  // R5: overrun condition raises the flag
  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEnable && startDetect && count == FULL && holdValid && !readPop) |=> overrunFlag);

  // R9: held character refills the store on a pop
  p_hold_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEnable && holdValid && readPop && count == FULL) |=> (count == FULL));

  // R10: push and pop at one entry keeps one entry
  p_simul_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEnable && count == CNT_W'(1) && readPop && charValid && !holdValid) |=> (count == CNT_W'(1)));
endmodule

// File: rtl/rx_buf_dpath.sv
module rx_buf_dpath
  import rx_buf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxBufStrobes_t     strb,
  input  logic              headValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFe,
  input  logic              inPe,
  output logic [DATA_W-1:0] headData,
  output logic              headFe,
  output logic              headPe
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] memData [DEPTH];
  logic [DEPTH-1:0]  memFe;
  logic [DEPTH-1:0]  memPe;
  logic [DATA_W-1:0] holdData;
  logic              holdFe;
  logic              holdPe;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] wrData;
  logic              wrFe;
  logic              wrPe;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wrData = strb.pushFromHold ? holdData : inData;
    wrFe   = strb.pushFromHold ? holdFe   : inFe;
    wrPe   = strb.pushFromHold ? holdPe   : inPe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) memData[i] <= '0;
      memFe    <= '0;
      memPe    <= '0;
      holdData <= '0;
      holdFe   <= 1'b0;
      holdPe   <= 1'b0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) begin
        memData[wrPtr] <= wrData;
        memFe[wrPtr]   <= wrFe;
        memPe[wrPtr]   <= wrPe;
        wrPtr          <= bump(wrPtr);
      end
      if (strb.pop) rdPtr <= bump(rdPtr);
      if (strb.loadHold) begin
        holdData <= inData;
        holdFe   <= inFe;
        holdPe   <= inPe;
      end
    end
  end

  assign headData = headValid ? memData[rdPtr] : '0;
  assign headFe   = headValid & memFe[rdPtr];
  assign headPe   = headValid & memPe[rdPtr];

  // R8: head stays put until popped
  p_head_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (headValid && !strb.pop && !strb.flush) |=> $stable(headData));
endmodule

// File: rtl/rx_buf_top.sv
module rx_buf_top
  import rx_buf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFrameErr,
  input  logic              charParityBad,
  input  logic              parityCheckEn,
  input  logic              startDetect,
  input  logic              readPop,
  output logic [7:0]        rxData,
  output logic              rxBit8,
  output logic              rxComplete,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrun
);
  rxBufStrobes_t     strb;
  logic              headValid;
  logic [DATA_W-1:0] headData;

  rx_buf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .charValid(charValid),
    .startDetect(startDetect), .readPop(readPop), .strb(strb),
    .headValid(headValid), .overrunFlag(overrun)
  );

  rx_buf_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .headValid(headValid),
    .inData(charData), .inFe(charFrameErr), .inPe(charParityBad & parityCheckEn),
    .headData(headData), .headFe(frameErr), .headPe(parityErr)
  );

  assign rxData     = headData[7:0];
  assign rxBit8     = headData[8];
  assign rxComplete = headValid;
endmodule

// File: tb/rx_buf_tb.sv
module rx_buf_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxEnable = 1'b0;
  logic       charValid = 1'b0;
  logic [8:0] charData = '0;
  logic       charFrameErr = 1'b0;
  logic       charParityBad = 1'b0;
  logic       parityCheckEn = 1'b0;
  logic       startDetect = 1'b0;
  logic       readPop = 1'b0;
  logic [7:0] rxData;
  logic       rxBit8, rxComplete, frameErr, parityErr, overrun;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  // expected item: {fe, pe, data[8:0]}
  logic [10:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_buf_top dut_i (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .charValid(charValid),
    .charData(charData), .charFrameErr(charFrameErr), .charParityBad(charParityBad),
    .parityCheckEn(parityCheckEn), .startDetect(startDetect), .readPop(readPop),
    .rxData(rxData), .rxBit8(rxBit8), .rxComplete(rxComplete),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: offers one character, model keeps store+hold (3 slots)
  task automatic sendChar(input logic [8:0] d, input logic fe, input logic pb, input logic pen);
    @(negedge clk);
    charValid = 1'b1; charData = d; charFrameErr = fe;
    charParityBad = pb; parityCheckEn = pen;
    @(negedge clk);
    charValid = 1'b0; charFrameErr = 1'b0; charParityBad = 1'b0;
    if (rxEnable && expQ.size() < 3) expQ.push_back({fe, pb & pen, d});
  endtask

  // monitor: compares head with the scoreboard, then pops it
  task automatic readCheck(input string req);
    logic [10:0] e;
    check(req, "rxComplete", int'(rxComplete), int'(expQ.size() > 0));
    if (expQ.size() > 0) begin
      e = expQ[0];
      check(req, "rxData", int'(rxData), int'(e[7:0]));
      check("R8", "rxBit8", int'(rxBit8), int'(e[8]));
      check("R3", "frameErr", int'(frameErr), int'(e[10]));
      check("R4", "parityErr", int'(parityErr), int'(e[9]));
      readPop = 1'b1;
      @(negedge clk);
      readPop = 1'b0;
      void'(expQ.pop_front());
    end
  endtask

  task automatic pulseStart();
    startDetect = 1'b1;
    @(negedge clk);
    startDetect = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2", "rxComplete reset", int'(rxComplete), 0);
    check("R2", "overrun reset", int'(overrun), 0);
    check("R2", "rxData reset", int'(rxData), 0);
    rst_n = 1'b1;
    rxEnable = 1'b1;
    @(negedge clk);

    // R4: bad parity while checking off is masked; R8 ninth bit
    sendChar(9'h1A5, 1'b0, 1'b1, 1'b0);
    check("R2", "rxComplete one", int'(rxComplete), 1);
    readCheck("R1");
    check("R2", "rxComplete empty", int'(rxComplete), 0);

    // R3/R4: flags travel with their own entry; R8 bit8 held
    sendChar(9'h13C, 1'b1, 1'b0, 1'b1);
    sendChar(9'h042, 1'b0, 1'b1, 1'b1);
    check("R8", "bit8 held after arrival", int'(rxBit8), 1);
    check("R3", "frameErr head", int'(frameErr), 1);
    readCheck("R3");
    readCheck("R4");

    // R5 negative: no held character -> no overrun
    sendChar(9'h011, 1'b0, 1'b0, 1'b0);
    sendChar(9'h122, 1'b0, 1'b0, 1'b0);
    pulseStart();
    check("R5", "overrun without hold", int'(overrun), 0);
    // R9: third waits in hold, fourth is discarded
    sendChar(9'h033, 1'b1, 1'b0, 1'b0);
    sendChar(9'h0FF, 1'b0, 1'b0, 1'b0);
    pulseStart();
    check("R5", "overrun set", int'(overrun), 1);
    @(negedge clk);
    check("R6", "overrun held", int'(overrun), 1);
    readCheck("R1");
    check("R6", "overrun cleared by pop", int'(overrun), 0);
    readCheck("R9");
    readCheck("R9");
    check("R9", "fourth discarded", int'(rxComplete), 0);

    // R10: push and pop in the same cycle with one entry
    sendChar(9'h055, 1'b0, 1'b0, 1'b0);
    check("R10", "head before", int'(rxData), 'h55);
    charValid = 1'b1; charData = 9'h1AA; readPop = 1'b1;
    @(negedge clk);
    charValid = 1'b0; readPop = 1'b0;
    void'(expQ.pop_front());
    expQ.push_back({1'b0, 1'b0, 9'h1AA});
    check("R10", "one entry kept", int'(rxComplete), 1);
    readCheck("R10");
    check("R10", "empty after", int'(rxComplete), 0);

    // R7: flush with full store, hold and overrun
    sendChar(9'h101, 1'b1, 1'b1, 1'b1);
    sendChar(9'h002, 1'b0, 1'b0, 1'b0);
    sendChar(9'h003, 1'b0, 1'b0, 1'b0);
    pulseStart();
    check("R5", "overrun before flush", int'(overrun), 1);
    rxEnable = 1'b0;
    charValid = 1'b1; charData = 9'h0EE;
    @(negedge clk);
    check("R7", "rxComplete flushed", int'(rxComplete), 0);
    check("R7", "overrun flushed", int'(overrun), 0);
    check("R7", "frameErr flushed", int'(frameErr), 0);
    check("R7", "parityErr flushed", int'(parityErr), 0);
    startDetect = 1'b1; readPop = 1'b1;
    @(negedge clk);
    charValid = 1'b0; startDetect = 1'b0; readPop = 1'b0;
    expQ.delete();
    rxEnable = 1'b1;
    @(negedge clk);
    check("R7", "inputs ignored while disabled", int'(rxComplete), 0);
    check("R7", "no overrun after disable", int'(overrun), 0);

    // R1 order after re-enable, hold stage drains (R9)
    sendChar(9'h0A1, 1'b0, 1'b0, 1'b0);
    sendChar(9'h1A2, 1'b0, 1'b0, 1'b0);
    sendChar(9'h0A3, 1'b0, 1'b1, 1'b1);
    readCheck("R1");
    readCheck("R9");
    readCheck("R1");
    check("R1", "drained", int'(rxComplete), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule